// File: doc/BRIEF.md
# Mode Register and Burst Column Sequencer

This block holds the burst and latency settings of a double-data-rate memory device. A load strobe carries a 12-bit opcode. The block checks the opcode and keeps its burst length, burst ordering and read latency fields. If any field carries a code that is not supported, the block keeps the old settings and raises an error flag instead. An accepted opcode can also request a delay-locked-loop reset, which the block turns into a single-cycle pulse.

The second half of the block is a burst sequencer. A start strobe captures a starting column, together with the burst length and ordering that are in force at that moment. From the next clock on, the block issues two column addresses per clock, because two data beats move per clock. Only the low bits inside the aligned burst block change; the bits above that block stay at the start column's value. A new start strobe restarts the sequence at once. A stop strobe ends the burst early.

Top module: `mode_burst_gen`

## Requirements
- R1: After reset the settings read burst length 2, sequential ordering and a latency of 4 half-cycles (2 clocks). `col_vld`, `mr_err` and `dll_rst` are low.
- R2: An accepted load takes effect on the outputs in the cycle after the strobe. The fields decode as follows. Opcode bits 2..0 give the burst length: 001 is 2, 010 is 4, 011 is 8. Opcode bit 3 gives the ordering: 0 is sequential, 1 is interleaved. Opcode bits 6..4 give the latency: 010 is 4 half-cycles, 110 is 5 half-cycles.
- R3: A load is rejected when it has a length code other than 001/010/011, a latency code other than 010/110, bit 7 set, or any of bits 11..9 set. A rejected load drives `mr_err` high for exactly the following cycle and leaves all three settings unchanged.
- R4: `dll_rst` is high for exactly the cycle after an accepted load with opcode bit 8 set. It stays low after a rejected load.
- R5: In sequential ordering, beat k has the in-block offset (start offset + k) mod BL.
- R6: In interleaved ordering, beat k has the in-block offset (start offset XOR k).
- R7: Column bits above the burst block stay equal to the start column for the whole burst. The length and ordering are taken when the burst starts; a load during the burst does not change them.
- R8: `col_vld` rises in the cycle after a start strobe and stays high for BL/2 cycles. In each of those cycles `col_a` carries beat 2j and `col_b` carries beat 2j+1.
- R9: A start strobe during a burst restarts the sequence at beat 0 of the new column in the next cycle.
- R10: A stop strobe drops `col_vld` in the next cycle. A start strobe in the same cycle as a stop takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mr_load | input | 1 | Load strobe for the opcode |
| mr_op | input | 12 | Mode opcode |
| bst_go | input | 1 | Burst start strobe |
| bst_col | input | 10 | Start column |
| bst_stop | input | 1 | Burst stop strobe |
| cas_half | output | 3 | Latency in half clock cycles (4 or 5) |
| burst_len | output | 4 | Burst length in beats (2, 4 or 8) |
| burst_type | output | 1 | 0 sequential, 1 interleaved |
| dll_rst | output | 1 | One-cycle DLL reset request |
| mr_err | output | 1 | One-cycle reserved-code error |
| col_vld | output | 1 | Column pair valid |
| col_a | output | 10 | Column of the even beat |
| col_b | output | 10 | Column of the odd beat |

## Verification
Every result comes one register stage after its cause. The settings, `mr_err` and `dll_rst` follow the edge that samples a load. The first column pair, a restart and the drop of `col_vld` after a stop all appear right after the edge that samples the strobe. The bench drives inputs on the falling edge. At each rising edge it advances a behavioural model with the values that were driven. It compares every output 1 ns after that edge, so the expected and actual values always refer to the same edge. The stimulus walks every start offset under each length and ordering, and also covers reserved codes, mid-burst loads, back-to-back restarts and stop-against-start collisions.

// File: rtl/mbg_pkg.sv
package mbg_pkg;

   // burst length held as a 2-bit code: 1 -> 2 beats, 2 -> 4, 3 -> 8
   typedef logic [1:0] bl_code_t;

   typedef enum logic {ORD_SEQ = 1'b0, ORD_INTL = 1'b1} ord_t;

   typedef struct packed {
      bl_code_t bl;
      ord_t     ord;
      logic     cl_half;   // 1: latency of 2.5 clocks
   } mode_t;

   localparam int unsigned BLK_W = 3;   // widest burst block is 8 beats

   // in-block offset mask for a length code
   function automatic logic [BLK_W-1:0] blk_mask(input bl_code_t c);
      return {c == 2'd3, c[1], 1'b1};
   endfunction

   // beat index of the final pair in a burst
   function automatic logic [BLK_W-1:0] last_pair(input bl_code_t c);
      logic [BLK_W-1:0] m;
      m = blk_mask(c);
      return {m[2:1], 1'b0};
   endfunction

endpackage

// File: rtl/mbg_mode_reg.sv
module mbg_mode_reg
   import mbg_pkg::*;
#(
   parameter int unsigned OP_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [OP_W-1:0] op,
   output mode_t           mode,
   output logic            err,
   output logic            dll_rst
);

   localparam int unsigned HI_LSB = 9;

   generate
      if (OP_W <= HI_LSB) begin : g_bad_w
         $error("mbg_mode_reg: OP_W must exceed %0d", HI_LSB);
      end
   endgenerate

   logic  len_ok;
   logic  lat_ok;
   logic  pad_ok;
   logic  accept;
   mode_t next_mode;

   always_comb begin
      len_ok = (op[2:0] == 3'b001) || (op[2:0] == 3'b010) || (op[2:0] == 3'b011);
      lat_ok = (op[6:4] == 3'b010) || (op[6:4] == 3'b110);
      pad_ok = (op[7] == 1'b0) && (op[OP_W-1:HI_LSB] == '0);
      accept = len_ok && lat_ok && pad_ok;
      next_mode.bl      = op[1:0];
      next_mode.ord     = ord_t'(op[3]);
      next_mode.cl_half = op[6];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode    <= '{bl: 2'd1, ord: ORD_SEQ, cl_half: 1'b0};
         err     <= 1'b0;
         dll_rst <= 1'b0;
      end else begin
         err     <= load && !accept;
         dll_rst <= load && accept && op[8];
         if (load && accept) begin
            mode <= next_mode;
         end
      end
   end

endmodule

// File: rtl/mbg_burst_seq.sv
module mbg_burst_seq
   import mbg_pkg::*;
#(
   parameter int unsigned COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [COL_W-1:0] col,
   input  logic             stop,
   input  mode_t            mode,
   output logic             act,
   output logic [COL_W-1:0] base,
   output logic [BLK_W-1:0] idx,
   output bl_code_t         bl_lat,
   output ord_t             ord_lat
);

   generate
      if (COL_W < BLK_W) begin : g_bad_w
         $error("mbg_burst_seq: COL_W must be at least %0d", BLK_W);
      end
   endgenerate

   logic at_end;
   assign at_end = (idx == last_pair(bl_lat));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act     <= 1'b0;
         base    <= '0;
         idx     <= '0;
         bl_lat  <= 2'd1;
         ord_lat <= ORD_SEQ;
      end else if (go) begin
         act     <= 1'b1;
         base    <= col;
         idx     <= '0;
         bl_lat  <= mode.bl;
         ord_lat <= mode.ord;
      end else if (stop) begin
         act <= 1'b0;
      end else if (act) begin
         if (at_end) begin
            act <= 1'b0;
         end else begin
            idx <= idx + BLK_W'(2);
         end
      end
   end

endmodule

// File: rtl/mbg_col_order.sv
module mbg_col_order
   import mbg_pkg::*;
#(
   parameter int unsigned COL_W = 10,
   parameter int unsigned LANE  = 0
) (
   input  logic [COL_W-1:0] base,
   input  bl_code_t         bl,
   input  ord_t             ord,
   input  logic [BLK_W-1:0] idx,
   output logic [COL_W-1:0] col
);

   logic [BLK_W-1:0] beat;
   logic [BLK_W-1:0] mask;
   logic [BLK_W-1:0] off;
   logic [BLK_W-1:0] seq_off;
   logic [BLK_W-1:0] intl_off;

   always_comb begin
      beat     = idx + BLK_W'(LANE);
      mask     = blk_mask(bl);
      seq_off  = (base[BLK_W-1:0] + beat) & mask;
      intl_off = (base[BLK_W-1:0] ^ beat) & mask;
      off      = (ord == ORD_INTL) ? intl_off : seq_off;
      col      = base;
      col[BLK_W-1:0] = (base[BLK_W-1:0] & ~mask) | off;
   end

endmodule

// File: rtl/mode_burst_gen.sv
module mode_burst_gen
   import mbg_pkg::*;
#(
   parameter int unsigned OP_W  = 12,
   parameter int unsigned COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mr_load,
   input  logic [OP_W-1:0]  mr_op,
   input  logic             bst_go,
   input  logic [COL_W-1:0] bst_col,
   input  logic             bst_stop,
   output logic [2:0]       cas_half,
   output logic [3:0]       burst_len,
   output logic             burst_type,
   output logic             dll_rst,
   output logic             mr_err,
   output logic             col_vld,
   output logic [COL_W-1:0] col_a,
   output logic [COL_W-1:0] col_b
);

   localparam int unsigned LANES = 2;   // two beats per clock

   mode_t            mode;
   logic [COL_W-1:0] base;
   logic [BLK_W-1:0] idx;
   bl_code_t         bl_lat;
   ord_t             ord_lat;
   logic [LANES-1:0][COL_W-1:0] lane_col;

   mbg_mode_reg #(.OP_W(OP_W)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (mr_load),
      .op      (mr_op),
      .mode    (mode),
      .err     (mr_err),
      .dll_rst (dll_rst)
   );

   mbg_burst_seq #(.COL_W(COL_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (bst_go),
      .col     (bst_col),
      .stop    (bst_stop),
      .mode    (mode),
      .act     (col_vld),
      .base    (base),
      .idx     (idx),
      .bl_lat  (bl_lat),
      .ord_lat (ord_lat)
   );

   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         mbg_col_order #(.COL_W(COL_W), .LANE(ln)) u_ord (
            .base (base),
            .bl   (bl_lat),
            .ord  (ord_lat),
            .idx  (idx),
            .col  (lane_col[ln])
         );
      end
   endgenerate

   assign col_a      = lane_col[0];
   assign col_b      = lane_col[1];
   assign cas_half   = mode.cl_half ? 3'd5 : 3'd4;
   assign burst_len  = 4'd1 << mode.bl;
   assign burst_type = mode.ord;

endmodule

// File: rtl/mode_burst_gen_chk.sv
module mode_burst_gen_chk #(
   parameter int unsigned COL_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bst_go,
   input logic             bst_stop,
   input logic             mr_err,
   input logic             dll_rst,
   input logic [2:0]       cas_half,
   input logic [3:0]       burst_len,
   input logic             burst_type,
   input logic             col_vld,
   input logic [COL_W-1:0] col_a,
   input logic [COL_W-1:0] col_b
);

   AST_MODE_HELD_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      mr_err |-> $stable(burst_len) && $stable(burst_type) && $stable(cas_half)); // R3

   AST_NO_DLL_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !(mr_err && dll_rst)); // R4

   AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(burst_len) == 1 && !burst_len[0]); // R2

   AST_LAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      cas_half == 3'd4 || cas_half == 3'd5); // R2

   AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      bst_go |=> col_vld); // R8

   AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      bst_stop && !bst_go |=> !col_vld); // R10

   AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      col_vld && $past(col_vld) && !$past(bst_go)
      |-> col_a[COL_W-1:3] == $past(col_a[COL_W-1:3])); // R7

   AST_PAIR_SAME_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      col_vld |-> col_a[COL_W-1:3] == col_b[COL_W-1:3] && col_a != col_b); // R8

endmodule

bind mode_burst_gen mode_burst_gen_chk #(.COL_W(COL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bst_go     (bst_go),
   .bst_stop   (bst_stop),
   .mr_err     (mr_err),
   .dll_rst    (dll_rst),
   .cas_half   (cas_half),
   .burst_len  (burst_len),
   .burst_type (burst_type),
   .col_vld    (col_vld),
   .col_a      (col_a),
   .col_b      (col_b)
);

// File: tb/mode_burst_gen_bench.sv
`timescale 1ns/1ps
module mode_burst_gen_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mr_load = 1'b0;
   logic [11:0] mr_op = '0;
   logic       bst_go = 1'b0;
   logic [9:0] bst_col = '0;
   logic       bst_stop = 1'b0;
   logic [2:0] cas_half;
   logic [3:0] burst_len;
   logic       burst_type;
   logic       dll_rst;
   logic       mr_err;
   logic       col_vld;
   logic [9:0] col_a;
   logic [9:0] col_b;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   int m_bl = 2, m_bt = 0, m_cl = 4, m_err = 0, m_dll = 0;
   int b_act = 0, b_start = 0, b_idx = 0, b_bl = 2, b_bt = 0;

   always #2 clk = ~clk;   // 250 MHz

   mode_burst_gen u_mode_burst_gen (
      .clk(clk), .rst_n(rst_n), .mr_load(mr_load), .mr_op(mr_op),
      .bst_go(bst_go), .bst_col(bst_col), .bst_stop(bst_stop),
      .cas_half(cas_half), .burst_len(burst_len), .burst_type(burst_type),
      .dll_rst(dll_rst), .mr_err(mr_err), .col_vld(col_vld),
      .col_a(col_a), .col_b(col_b)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_col(input int start, input int k, input int bl, input int bt);
      int mask, off;
      mask = bl - 1;
      off  = bt ? ((start & mask) ^ k) : ((start + k) & mask);
      return (start & ~mask & 1023) | off;
   endfunction

   function automatic int dec_len(input logic [11:0] op);
      case (op[2:0])
         3'b001: return 2;
         3'b010: return 4;
         3'b011: return 8;
         default: return 0;
      endcase
   endfunction

   function automatic int dec_lat(input logic [11:0] op);
      if (op[6:4] == 3'b010) return 4;
      if (op[6:4] == 3'b110) return 5;
      return 0;
   endfunction

   // advance the model with the values sampled at this edge
   task automatic model_edge();
      int nbl, ncl;
      if (bst_go) begin
         b_act = 1; b_start = int'(bst_col); b_idx = 0; b_bl = m_bl; b_bt = m_bt;
      end else if (bst_stop) begin
         b_act = 0;
      end else if (b_act != 0) begin
         if (b_idx + 2 >= b_bl) b_act = 0;
         else b_idx = b_idx + 2;
      end
      m_err = 0; m_dll = 0;
      if (mr_load) begin
         nbl = dec_len(mr_op);
         ncl = dec_lat(mr_op);
         if (nbl == 0 || ncl == 0 || mr_op[7] || mr_op[11:9] != 3'b000) begin
            m_err = 1;
         end else begin
            m_bl = nbl; m_bt = int'(mr_op[3]); m_cl = ncl; m_dll = int'(mr_op[8]);
         end
      end
   endtask

   task automatic compare();
      string ord_req;
      ord_req = (b_bt != 0) ? "R6 interleaved order" : "R5 sequential order";
      chk(int'(burst_len) == m_bl, "R2 burst_len", int'(burst_len), m_bl);
      chk(int'(burst_type) == m_bt, "R2 burst_type", int'(burst_type), m_bt);
      chk(int'(cas_half) == m_cl, "R2 cas_half", int'(cas_half), m_cl);
      chk(int'(mr_err) == m_err, "R3 mr_err", int'(mr_err), m_err);
      chk(int'(dll_rst) == m_dll, "R4 dll_rst", int'(dll_rst), m_dll);
      chk(int'(col_vld) == b_act, "R8 col_vld", int'(col_vld), b_act);
      if (b_act != 0 && col_vld) begin
         chk(int'(col_a) == exp_col(b_start, b_idx, b_bl, b_bt), ord_req,
             int'(col_a), exp_col(b_start, b_idx, b_bl, b_bt));
         chk(int'(col_b) == exp_col(b_start, b_idx + 1, b_bl, b_bt), ord_req,
             int'(col_b), exp_col(b_start, b_idx + 1, b_bl, b_bt));
      end
   endtask

   // one clock: drive after the falling edge, model at the rising edge, compare 1 ns later
   task automatic step(input logic ld, input logic [11:0] op, input logic go,
                       input logic [9:0] col, input logic stp);
      mr_load = ld; mr_op = op; bst_go = go; bst_col = col; bst_stop = stp;
      @(posedge clk);
      model_edge();
      #1;
      compare();
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 12'h000, 1'b0, 10'h000, 1'b0);
   endtask

   task automatic load(input logic [11:0] op);
      step(1'b1, op, 1'b0, 10'h000, 1'b0);
   endtask

   task automatic burst(input logic [9:0] col);
      step(1'b0, 12'h000, 1'b1, col, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      // R1: reset state
      chk(burst_len == 4'd2, "R1 reset burst_len", int'(burst_len), 2);
      chk(burst_type == 1'b0, "R1 reset burst_type", int'(burst_type), 0);
      chk(cas_half == 3'd4, "R1 reset cas_half", int'(cas_half), 4);
      chk(col_vld == 1'b0, "R1 reset col_vld", int'(col_vld), 0);
      chk(mr_err == 1'b0 && dll_rst == 1'b0, "R1 reset flags",
          int'({mr_err, dll_rst}), 0);
      @(negedge clk);
      idle(2);

      // burst with the default settings (R5, R8)
      burst(10'h005); idle(2);

      // every length, ordering and start offset (R2, R5, R6, R7, R8)
      for (int bt = 0; bt < 2; bt++) begin
         for (int lc = 1; lc <= 3; lc++) begin
            load(12'(32'h020 | (bt << 3) | lc));
            for (int s = 0; s < 8; s++) begin
               burst(10'(32'h2A8 + s));
               idx_wait: for (int w = 0; w < 4; w++) idle(1);
            end
         end
      end

      // latency 2.5 with DLL reset request (R2, R4)
      load(12'h16B); burst(10'h2F5); idle(5);
      // BL4 interleaved, upper bits all ones (R7)
      load(12'h02A); burst(10'h3FE); idle(3);

      // reserved codes keep the settings (R3), no DLL pulse (R4)
      load(12'h120);   // length 000
      load(12'h013);   // latency 001
      load(12'h127);   // length 111, DLL bit set
      load(12'h0A3);   // bit 7 set
      load(12'h423);   // bit 10 set
      load(12'h073);   // latency 111
      idle(1);

      // mid-burst load does not alter the running burst (R7)
      load(12'h023);
      burst(10'h133);
      load(12'h029);   // BL2 interleaved, takes effect for the next burst only
      idle(4);
      burst(10'h133); idle(2);

      // restart one and two clocks into a burst (R9)
      load(12'h02B);
      burst(10'h011); burst(10'h0F6); idle(1); burst(10'h203); idle(5);

      // early stop, and start beating stop in the same cycle (R10)
      burst(10'h144); idle(1); step(1'b0, 12'h000, 1'b0, 10'h000, 1'b1); idle(2);
      burst(10'h144); step(1'b0, 12'h000, 1'b1, 10'h3A1, 1'b1); idle(5);
      step(1'b0, 12'h000, 1'b0, 10'h000, 1'b1); idle(1);
      // load and burst on the same edge: burst uses the old setting (R7)
      step(1'b1, 12'h022, 1'b1, 10'h0C7, 1'b0); idle(5);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule